// File: doc/BRIEF.md
# Phase-Adjustable Integer Clock Divider

This block divides a fast source clock by a programmable integer and places the divided output at a phase offset with half-step resolution. The block clock `clk_i` runs at twice the distribution rate, so one `clk_i` cycle is one half-step, which is half a period of the distribution clock. The output is high for N half-steps and then low for N half-steps, with N the clamped divide value. A divide by N therefore gives a 50% duty cycle for both even and odd N.

A one-cycle pulse on `sync_i` samples the divide value, the integer delay and the half-step flag. It forces the output low and holds it low for D half-steps, with D = 2*delay - half. In distribution cycles this is the delay field minus 0.5 when the flag is set. The output then restarts with a full high phase. The offset is counted from the sync edge, so a repeated sync with unchanged settings shifts the output by the same amount again, relative to its current phase. Software computes the delay values. A larger delay reaches the same relative phase as a smaller one, but keeps the output off for longer.

Top module: `clkdiv_hs`

## Requirements
- R1: After reset, `clk_o` is low and stays low until the first `sync_i` pulse.
- R2: Once running, `clk_o` is high for N cycles and then low for N cycles, repeating. N is `div_i` sampled at sync and clamped to the range 2..1045. The first high phase after a hold is a full N cycles.
- R3: The sample edge of `sync_i` drives `clk_o` low, and `clk_o` stays low until the hold ends.
- R4: `clk_o` rises D clock edges after the sync sample edge, with D = 2*`dly_i` - `half_i` (`half_i`=1 subtracts one half-step).
- R5: When `dly_i` < 5, D is clamped to 9, which is a 4.5-cycle distribution delay and the smallest legal value.
- R6: `div_i`, `dly_i` and `half_i` are used only at the sync sample edge. Changing them later has no effect on the output.
- R7: A sync with unchanged settings applies the same delay again, measured from that sync. A sync during a hold restarts the hold.
- R8: A sync that falls on the same edge as a scheduled output toggle wins: the output goes or stays low and the hold begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-step clock (2x distribution rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Divide value, clamped to 2..1045 |
| dly_i | input | DLY_W | Integer delay field, distribution cycles |
| half_i | input | 1 | Subtract one half-step from the delay |
| sync_i | input | 1 | One-cycle pulse that applies the settings |
| clk_o | output | 1 | Divided clock |

## Verification
A sync pulse and a scheduled output toggle can land on the same clock edge. The same holds for a sync pulse and the end of a running hold. The bench tracks a running output and places the sync exactly on the edge where the output would rise. It then checks that the output stays low and rises only after the full new delay. It also issues a second sync a few cycles into a hold and checks that the delay is counted from the second pulse. Delays are measured edge by edge from the sync sample edge and compared against values derived from the clamp rules.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned DIV_MIN  = 2;
  localparam int unsigned DIV_MAX  = 1045;
  localparam int unsigned HOLD_MIN = 9;  // half-steps, = 4.5 distribution cycles
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
  parameter int DIV_W = 11,
  parameter int DLY_W = 11,
  localparam int HW = DLY_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             half_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic [HW-1:0]    hold_len_o
);
  import clkdiv_pkg::*;
  localparam int DLY_FLOOR = (HOLD_MIN + 1) / 2;

  logic [DIV_W-1:0] div_c;

  always_comb begin
    if (div_i < DIV_W'(DIV_MIN))      div_c = DIV_W'(DIV_MIN);
    else if (div_i > DIV_W'(DIV_MAX)) div_c = DIV_W'(DIV_MAX);
    else                              div_c = div_i;
  end

  // hold length in half-steps, clamped to the legal minimum
  always_comb begin
    if (dly_i < DLY_W'(DLY_FLOOR)) hold_len_o = HW'(HOLD_MIN);
    else                           hold_len_o = {dly_i, 1'b0} - HW'(half_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_div_o <= DIV_W'(DIV_MIN);
    else if (sync_i) act_div_o <= div_c;
  end
endmodule

// File: rtl/clkdiv_hold.sv
module clkdiv_hold #(
  parameter int HW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [HW-1:0] hold_len_i,
  output logic          busy_o,
  output logic          release_o
);
  logic [HW-1:0] cnt_q;

  assign release_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (sync_i) begin
      cnt_q  <= hold_len_i - HW'(1);
      busy_o <= 1'b1;
    end else if (release_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - HW'(1);
    end
  end
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
  parameter int DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             release_i,
  input  logic [DIV_W-1:0] act_div_i,
  output logic             running_o,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      running_o <= 1'b0;
      clk_o     <= 1'b0;
    end else if (sync_i) begin
      cnt_q     <= '0;
      running_o <= 1'b0;
      clk_o     <= 1'b0;
    end else if (release_i) begin
      cnt_q     <= '0;
      running_o <= 1'b1;
      clk_o     <= 1'b1;
    end else if (running_o) begin
      if (cnt_q == act_div_i - DIV_W'(1)) begin
        cnt_q <= '0;
        clk_o <= ~clk_o;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/clkdiv_hs.sv
module clkdiv_hs #(
  parameter int DIV_W = 11,
  parameter int DLY_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             half_i,
  input  logic             sync_i,
  output logic             clk_o
);
  localparam int HW = DLY_W + 1;

  logic [DIV_W-1:0] act_div;
  logic [HW-1:0]    hold_len;
  logic             hold_busy, hold_rel, running;

  clkdiv_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
    .clk_i, .rst_ni, .sync_i, .div_i, .dly_i, .half_i,
    .act_div_o(act_div), .hold_len_o(hold_len)
  );

  clkdiv_hold #(.HW(HW)) u_hold (
    .clk_i, .rst_ni, .sync_i, .hold_len_i(hold_len),
    .busy_o(hold_busy), .release_o(hold_rel)
  );

  clkdiv_phase #(.DIV_W(DIV_W)) u_phase (
    .clk_i, .rst_ni, .sync_i, .release_i(hold_rel), .act_div_i(act_div),
    .running_o(running), .clk_o
  );
endmodule

// File: rtl/clkdiv_hs_chk.sv
module clkdiv_hs_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             clk_o,
  input logic             hold_busy,
  input logic             hold_rel,
  input logic             running,
  input logic [DIV_W-1:0] act_div
);
  import clkdiv_pkg::*;

  a_r3_sync_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !clk_o);

  a_r3_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_busy |-> !clk_o);

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !hold_busy) |-> !clk_o);

  a_r5_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (hold_busy && !hold_rel));

  a_r4_rise_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rel && !sync_i |=> (clk_o && running));

  a_r2_div_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div >= DIV_W'(DIV_MIN)) && (act_div <= DIV_W'(DIV_MAX)));
endmodule

bind clkdiv_hs clkdiv_hs_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i, .rst_ni, .sync_i, .clk_o,
  .hold_busy, .hold_rel, .running, .act_div
);

// File: tb/sim_clkdiv_hs.sv
module sim_clkdiv_hs;
  localparam int DIV_W = 11;
  localparam int DLY_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div;
  logic [DLY_W-1:0] dly;
  logic half, sync;
  logic clk_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkdiv_hs #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .dly_i(dly),
    .half_i(half), .sync_i(sync), .clk_o(clk_out)
  );

  typedef struct packed { int dv; int dl; int hf; int exp_d; int exp_n; } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{5,    14,  1, 27,  5},     // R4 odd divide, half set
    '{4,    14,  0, 28,  4},     // R4 even divide
    '{2,    5,   1, 9,   2},     // R5 exact minimum
    '{1,    3,   0, 9,   2},     // R5 clamp, R2 div floor
    '{0,    0,   1, 9,   2},     // R5 zero field with half set
    '{1045, 6,   0, 12,  1045},  // R2 maximum divide
    '{2000, 5,   0, 10,  1045},  // R2 divide ceiling clamp
    '{7,    100, 1, 199, 7}      // R4 long hold
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int m_d, m_hi, m_lo, m_low0;

  // drive settings and a sync at a negedge; post_* take effect after the sample edge
  task automatic sync_measure(input int dv, dl, hf, pdv, pdl, phf);
    div = DIV_W'(dv); dly = DLY_W'(dl); half = hf[0]; sync = 1'b1;
    @(posedge clk); @(negedge clk);
    sync = 1'b0;
    div = DIV_W'(pdv); dly = DLY_W'(pdl); half = phf[0];
    m_low0 = (clk_out == 1'b0);
    m_d = 0;
    while (clk_out == 1'b0 && m_d < 6000) begin @(posedge clk); @(negedge clk); m_d++; end
    m_hi = 0;
    while (clk_out == 1'b1 && m_hi < 3000) begin @(posedge clk); @(negedge clk); m_hi++; end
    m_lo = 0;
    while (clk_out == 1'b0 && m_lo < 3000) begin @(posedge clk); @(negedge clk); m_lo++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int toggles;
    div = '0; dly = '0; half = 1'b0; sync = 1'b0;
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b0, "R1 reset low", int'(clk_out), 0);
    rst_n = 1'b1;
    toggles = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (clk_out) toggles++;
    end
    chk(toggles == 0, "R1 idle without sync", toggles, 0);

    for (int v = 0; v < NV; v++) begin
      sync_measure(VEC[v].dv, VEC[v].dl, VEC[v].hf, VEC[v].dv, VEC[v].dl, VEC[v].hf);
      chk(m_low0 == 1, $sformatf("R3 low after sync v%0d", v), m_low0, 1);
      chk(m_d == VEC[v].exp_d, $sformatf("R4/R5 delay v%0d", v), m_d, VEC[v].exp_d);
      chk(m_hi == VEC[v].exp_n, $sformatf("R2 high v%0d", v), m_hi, VEC[v].exp_n);
      chk(m_lo == VEC[v].exp_n, $sformatf("R2 low v%0d", v), m_lo, VEC[v].exp_n);
    end

    // R6: settings changed right after the sync edge are ignored
    sync_measure(3, 10, 1, 9, 50, 0);
    chk(m_d == 19, "R6 delay uses sampled half", m_d, 19);
    chk(m_hi == 3 && m_lo == 3, "R6 divide uses sampled value", m_hi, 3);

    // R7: repeated sync with unchanged setting re-applies the same delay
    sync_measure(3, 10, 1, 3, 10, 1);
    chk(m_d == 19, "R7 repeated sync delay", m_d, 19);

    // R7: sync during a hold restarts the count
    div = 3; dly = 10; half = 1'b0; sync = 1'b1;
    @(posedge clk); @(negedge clk); sync = 1'b0;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    chk(clk_out == 1'b0, "R3 low during hold", int'(clk_out), 0);
    sync_measure(3, 6, 0, 3, 6, 0);
    chk(m_d == 12, "R7 restart during hold", m_d, 12);
    chk(m_hi == 3, "R2 full first pulse after restart", m_hi, 3);

    // R8: sync on the edge where the output would rise (now just past a rise, N=3)
    repeat (5) begin @(posedge clk); @(negedge clk); end
    sync_measure(3, 7, 1, 3, 7, 1);
    chk(m_low0 == 1, "R8 sync beats rising toggle", m_low0, 1);
    chk(m_d == 13, "R8 delay after coincident sync", m_d, 13);

    // R8: sync on a falling toggle edge
    repeat (2) begin @(posedge clk); @(negedge clk); end
    sync_measure(4, 8, 0, 4, 8, 0);
    chk(m_d == 16, "R8 delay after sync on fall edge", m_d, 16);
    chk(m_hi == 4, "R2 high after coincident sync", m_hi, 4);

    finish_run();
  end
endmodule